// File: doc/BRIEF.md
# 12-bit 4:4:4 Slice Splitter

This block turns 12-bit three-component pixels into pairs of 10-bit words on two parallel streams of a double-rate video interface. A pixel (red/green/blue, or Cr/Y/Cb in that same order) is offered on one clock of every two. Over the next two clocks the block emits two words on each stream. Every word carries the same 3-bit slice of all three components. Stream one carries the top slice and then the slice below the middle. Stream two carries the slice just under the top and then the bottom slice. The top bit of every pixel word is the inverse of the bit under it, which keeps pixel words away from reserved code values.

The timing reference, line number, CRC and ancillary words are produced elsewhere. They enter on a passthrough port and are placed on the streams unchanged. A passthrough word always takes the next output slot. If it lands where a pixel's second word was due, the pending word is dropped and the word phase returns to "first". The first pixel after a start-of-line sequence therefore always opens with its first word, and no pixel straddles that boundary.

Top module: `pix12_slice_splitter`

## Requirements
- R1: While reset is high, and on the first output after it, `out_vld`, `out_phase`, `out_s1` and `out_s2` are all zero.
- R2: For an accepted pixel, stream one carries component bits [11:9] in the first word and bits [5:3] in the second word.
- R3: For an accepted pixel, stream two carries component bits [8:6] in the first word and bits [2:0] in the second word.
- R4: Inside each pixel word, the red (Cr) slice sits at bits 8..6, the green (Y) slice at bits 5..3 and the blue (Cb) slice at bits 2..0.
- R5: Bit 9 of every pixel word is the inverse of bit 8.
- R6: A pixel sampled with `pix_vld` high in the first-word phase appears as its first words one clock later, with `out_phase`=0. Its second words follow on the next clock with `out_phase`=1.
- R7: `pix_vld` in the clock where a second word is pending has no effect. The output that follows is the earlier pixel's second word, and the next clock is idle.
- R8: A word sampled with `pt_vld` high appears unchanged on both streams one clock later, with `out_vld`=1 and `out_phase`=0. It wins over a simultaneous `pix_vld`, and that pixel is not accepted.
- R9: `pt_vld` in the clock where a second word is pending drops that word and returns the phase to first. A pixel offered after it starts with its first words.
- R10: With no valid input and no pending second word, the next output has `out_vld`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_vld | input | 1 | Pixel strobe, one clock per pixel |
| pix_r | input | 12 | Red or Cr component |
| pix_g | input | 12 | Green or Y component |
| pix_b | input | 12 | Blue or Cb component |
| pt_vld | input | 1 | Passthrough word strobe |
| pt_s1 | input | 10 | Passthrough word for stream one |
| pt_s2 | input | 10 | Passthrough word for stream two |
| out_vld | output | 1 | Output words valid |
| out_phase | output | 1 | 1 when the words are a pixel's second words |
| out_s1 | output | 10 | Stream one word |
| out_s2 | output | 10 | Stream two word |

## Verification
Two functions can fall in the same cycle. One is the pending second word of a pixel; the other is either a passthrough word or a fresh pixel strobe. The bench provokes both cases. It raises `pix_vld` again in the pending slot, where the strobe must be ignored and the held second words must come out. It places a passthrough word in that slot, where the passthrough words must win, the following cycle must be idle, and the next pixel must start at its first word. A 4096-value sweep over every component value, with expected words computed by shifts and masks, covers slice placement and the bit-9 rule.

// File: rtl/splt_pkg.sv
package splt_pkg;

    localparam int COMP_W    = 12;
    localparam int SLICE_W   = 3;
    localparam int NUM_SLICE = COMP_W / SLICE_W;
    localparam int WORD_W    = 3 * SLICE_W + 1;

    typedef logic [SLICE_W-1:0] slice_t;
    typedef logic [WORD_W-1:0]  word_t;

    typedef struct packed {
        logic [COMP_W-1:0] r;
        logic [COMP_W-1:0] g;
        logic [COMP_W-1:0] b;
    } pix_t;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_PASS   = 2'd1,
        SEL_FIRST  = 2'd2,
        SEL_SECOND = 2'd3
    } sel_e;

    typedef struct packed {
        logic  vld;
        logic  phase;
        word_t s1;
        word_t s2;
    } out_t;

    // Red slice on top, then green, then blue; top bit guards against reserved codes.
    function automatic word_t pack_word(input slice_t a, input slice_t b, input slice_t c);
        word_t w;
        w = {1'b0, a, b, c};
        w[WORD_W-1] = ~a[SLICE_W-1];
        return w;
    endfunction

endpackage

// File: rtl/splt_word_fmt.sv
module splt_word_fmt
    import splt_pkg::*;
(
    input  pix_t                        pix,
    output word_t [NUM_SLICE-1:0]       slice_word
);
    // slice_word[0] = top slice ... slice_word[NUM_SLICE-1] = bottom slice
    for (genvar k = 0; k < NUM_SLICE; k++) begin : g_slice
        localparam int LSB = COMP_W - SLICE_W * (k + 1);
        assign slice_word[k] = pack_word(pix.r[LSB +: SLICE_W],
                                         pix.g[LSB +: SLICE_W],
                                         pix.b[LSB +: SLICE_W]);
    end
endmodule

// File: rtl/splt_seq.sv
module splt_seq
    import splt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pix_vld,
    input  logic pt_vld,
    output sel_e sel,
    output logic pend_q
);
    always_comb begin
        if (pt_vld)       sel = SEL_PASS;
        else if (pend_q)  sel = SEL_SECOND;
        else if (pix_vld) sel = SEL_FIRST;
        else              sel = SEL_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= (sel == SEL_FIRST);
    end
endmodule

// File: rtl/pix12_slice_splitter.sv
module pix12_slice_splitter
    import splt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pix_vld,
    input  logic [COMP_W-1:0] pix_r,
    input  logic [COMP_W-1:0] pix_g,
    input  logic [COMP_W-1:0] pix_b,
    input  logic              pt_vld,
    input  logic [WORD_W-1:0] pt_s1,
    input  logic [WORD_W-1:0] pt_s2,
    output logic              out_vld,
    output logic              out_phase,
    output logic [WORD_W-1:0] out_s1,
    output logic [WORD_W-1:0] out_s2
);
    localparam int HALF = NUM_SLICE / 2;

    pix_t                  pix;
    word_t [NUM_SLICE-1:0] slice_word;
    sel_e                  sel;
    logic                  pend_q;
    word_t                 hold_s1, hold_s2;
    out_t                  nxt, out_q;

    assign pix = '{r: pix_r, g: pix_g, b: pix_b};

    splt_word_fmt u_fmt (
        .pix        (pix),
        .slice_word (slice_word)
    );

    splt_seq u_seq (
        .clk     (clk),
        .rst     (rst),
        .pix_vld (pix_vld),
        .pt_vld  (pt_vld),
        .sel     (sel),
        .pend_q  (pend_q)
    );

    // Second-word pair stored already formatted.
    always_ff @(posedge clk) begin
        if (rst) begin
            hold_s1 <= '0;
            hold_s2 <= '0;
        end else if (sel == SEL_FIRST) begin
            hold_s1 <= slice_word[HALF];
            hold_s2 <= slice_word[HALF+1];
        end
    end

    always_comb begin
        nxt = '0;
        unique case (sel)
            SEL_PASS:   nxt = '{vld: 1'b1, phase: 1'b0, s1: pt_s1, s2: pt_s2};
            SEL_FIRST:  nxt = '{vld: 1'b1, phase: 1'b0, s1: slice_word[0], s2: slice_word[1]};
            SEL_SECOND: nxt = '{vld: 1'b1, phase: 1'b1, s1: hold_s1, s2: hold_s2};
            default:    nxt = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= nxt;
    end

    assign out_vld   = out_q.vld;
    assign out_phase = out_q.phase;
    assign out_s1    = out_q.s1;
    assign out_s2    = out_q.s2;
endmodule

// File: rtl/splt_checker.sv
module splt_checker
    import splt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              pix_vld,
    input logic [COMP_W-1:0] pix_r,
    input logic [COMP_W-1:0] pix_b,
    input logic              pt_vld,
    input logic [WORD_W-1:0] pt_s1,
    input logic [WORD_W-1:0] pt_s2,
    input logic              out_vld,
    input logic              out_phase,
    input logic [WORD_W-1:0] out_s1,
    input logic [WORD_W-1:0] out_s2,
    input logic              pend_q
);
    p_pass_r8: assert property (@(posedge clk) disable iff (rst)
        pt_vld |=> (out_vld && !out_phase && out_s1 == $past(pt_s1) && out_s2 == $past(pt_s2)));

    p_first_r2: assert property (@(posedge clk) disable iff (rst)
        (pix_vld && !pt_vld && !pend_q) |=>
            (out_vld && !out_phase && out_s1[8:6] == $past(pix_r[11:9])
             && out_s2[2:0] == $past(pix_b[8:6])));

    p_second_r6: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !pt_vld) |=> (out_vld && out_phase));

    p_bit9_r5: assert property (@(posedge clk) disable iff (rst)
        out_phase |-> (out_s1[9] != out_s1[8] && out_s2[9] != out_s2[8]));

    p_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (pend_q && pt_vld) |=> (!pend_q && !out_phase));

    p_ignore_r7: assert property (@(posedge clk) disable iff (rst)
        pend_q |=> !pend_q);

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!pt_vld && !pix_vld && !pend_q) |=> !out_vld);
endmodule

bind pix12_slice_splitter splt_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .pix_vld   (pix_vld),
    .pix_r     (pix_r),
    .pix_b     (pix_b),
    .pt_vld    (pt_vld),
    .pt_s1     (pt_s1),
    .pt_s2     (pt_s2),
    .out_vld   (out_vld),
    .out_phase (out_phase),
    .out_s1    (out_s1),
    .out_s2    (out_s2),
    .pend_q    (pend_q)
);

// File: tb/pix12_slice_splitter_bench.sv
module pix12_slice_splitter_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_vld = 1'b0;
    logic [11:0] pix_r = '0, pix_g = '0, pix_b = '0;
    logic        pt_vld = 1'b0;
    logic [9:0]  pt_s1 = '0, pt_s2 = '0;
    logic        out_vld, out_phase;
    logic [9:0]  out_s1, out_s2;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pix12_slice_splitter u_pix12_slice_splitter (
        .clk(clk), .rst(rst), .pix_vld(pix_vld),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .pt_vld(pt_vld), .pt_s1(pt_s1), .pt_s2(pt_s2),
        .out_vld(out_vld), .out_phase(out_phase),
        .out_s1(out_s1), .out_s2(out_s2)
    );

    // Expected pixel word: slices at bits 8..6 / 5..3 / 2..0, bit 9 = not bit 8.
    function automatic logic [9:0] ew(int r, int g, int b, int sh);
        int a, m, c, w;
        a = (r >> sh) & 7;
        m = (g >> sh) & 7;
        c = (b >> sh) & 7;
        w = a * 64 + m * 8 + c;
        if (a < 4) w = w + 512;
        return w[9:0];
    endfunction

    task automatic check(string req, logic [21:0] act, logic [21:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual vld/ph/s1/s2=%h expected %h", req, act, exp);
        end
    endtask

    // Apply inputs, clock once, land 2 ns after the edge.
    task automatic cyc(logic pv, int r, int g, int b, logic tv, int t1, int t2);
        pix_vld = pv;
        pix_r = r[11:0]; pix_g = g[11:0]; pix_b = b[11:0];
        pt_vld = tv;
        pt_s1 = t1[9:0]; pt_s2 = t2[9:0];
        @(posedge clk);
        #2;
    endtask

    task automatic expect_pix(string req, logic ph, int r, int g, int b);
        if (!ph) check(req, {out_vld, out_phase, out_s1, out_s2}, {1'b1, 1'b0, ew(r,g,b,9), ew(r,g,b,6)});
        else     check(req, {out_vld, out_phase, out_s1, out_s2}, {1'b1, 1'b1, ew(r,g,b,3), ew(r,g,b,0)});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state
        check("R1", {out_vld, out_phase, out_s1, out_s2}, 22'd0);
        rst = 1'b0;
        cyc(0, 0, 0, 0, 0, 0, 0);
        check("R1 after release", {out_vld, out_phase, out_s1, out_s2}, 22'd0);

        // R2 R3 R4 R5 R6 R7: sweep of every component value
        for (int v = 0; v < 4096; v++) begin
            int r, g, b;
            r = v;
            g = (v * 7 + 1000) % 4096;
            b = 4095 - v;
            cyc(1, r, g, b, 0, 0, 0);
            expect_pix("R2/R3/R4/R6 first word", 1'b0, r, g, b);
            // R7: every third pixel, a stray strobe in the pending slot
            cyc((v % 3) == 0, b, r, g, 0, 0, 0);
            expect_pix("R2/R3/R5/R6/R7 second word", 1'b1, r, g, b);
            checks++;
            if (out_s1[9] == out_s1[8] || out_s2[9] == out_s2[8]) begin
                errors++;
                $display("FAIL R5: actual s1=%h s2=%h expected bit9 != bit8", out_s1, out_s2);
            end
        end
        // R7: the stray strobe must not have started a pair
        cyc(0, 0, 0, 0, 0, 0, 0);
        check("R7 no extra pair", {out_vld, 21'd0}, 22'd0);

        // R8: passthrough words unchanged
        for (int i = 0; i < 64; i++) begin
            int t1, t2;
            t1 = (i * 13 + 3) % 1024;
            t2 = 1023 - i * 5;
            cyc(i[0], 4095, 0, 4095, 1, t1, t2);
            check("R8 passthrough", {out_vld, out_phase, out_s1, out_s2},
                  {1'b1, 1'b0, t1[9:0], t2[9:0]});
        end
        // R8: the pixel offered together with the last passthrough was not accepted
        cyc(0, 0, 0, 0, 0, 0, 0);
        check("R8 pixel lost to passthrough", {out_vld, 21'd0}, 22'd0);

        // R10: idle
        cyc(0, 0, 0, 0, 0, 0, 0);
        check("R10 idle", {out_vld, 21'd0}, 22'd0);

        // R9: passthrough in the pending slot aborts the second word
        cyc(1, 12'hABC, 12'h123, 12'hFED, 0, 0, 0);
        expect_pix("R9 first word before abort", 1'b0, 12'hABC, 12'h123, 12'hFED);
        cyc(0, 0, 0, 0, 1, 10'h3FF, 10'h000);
        check("R9 passthrough wins slot", {out_vld, out_phase, out_s1, out_s2},
              {1'b1, 1'b0, 10'h3FF, 10'h000});
        cyc(0, 0, 0, 0, 0, 0, 0);
        check("R9 phase back to first", {out_vld, out_phase, 20'd0}, 22'd0);
        cyc(1, 12'h0F0, 12'hF0F, 12'h555, 0, 0, 0);
        expect_pix("R9 next pixel first word", 1'b0, 12'h0F0, 12'hF0F, 12'h555);
        cyc(0, 0, 0, 0, 0, 0, 0);
        expect_pix("R9 next pixel second word", 1'b1, 12'h0F0, 12'hF0F, 12'h555);
        cyc(0, 0, 0, 0, 0, 0, 0);
        check("R10 idle after pair", {out_vld, 21'd0}, 22'd0);

        // R1: reset mid-pair clears everything
        cyc(1, 12'h777, 12'h888, 12'h999, 0, 0, 0);
        rst = 1'b1;
        cyc(0, 0, 0, 0, 0, 0, 0);
        check("R1 reset mid-pair", {out_vld, out_phase, out_s1, out_s2}, 22'd0);
        rst = 1'b0;
        cyc(0, 0, 0, 0, 0, 0, 0);
        check("R1 no leftover second word", {out_vld, out_phase, out_s1, out_s2}, 22'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule